// File: doc/BRIEF.md
# SECDED Check-Byte Encoder and Read Corrector for 64-bit Memory Words

This block guards a 64-bit memory word with an 8-bit check byte. On the write side it turns the data word into its check byte in the same cycle, so the memory stores the two side by side. On the read side it takes the returned word and its stored check byte. It recomputes the check byte and XORs the two into a syndrome. From the syndrome it sorts the read into one of three cases: clean, one bit wrong (corrected), or two bits wrong (flagged, not corrected).

The code is not plain parity. A fixed inversion constant of 0x0C is folded into every check byte, so zero-filled memory holds the check byte 0x0C. The same constant is folded into the recomputed byte, so it cancels in the syndrome. Address bits play no part in the code. The read result is registered and appears one clock after the read strobe.

Top module: `secded_ecc_unit`

## Requirements
- R1: An all-zero data word encodes to the check byte 0x0C on `enc_check`.
- R2: The column code of data bit 0 is 0xE3. Data bits 1..63 take, in ascending numeric order, the byte values whose weight is 3 or 5, leaving out 0xE3. `enc_check` equals the XOR of the columns of all set data bits, XORed with 0x0C. Bit r of `enc_check` is row r.
- R3: `chk_syndrome` equals the stored check byte XOR the check byte recomputed from the read data. A read whose check byte matches its data gives syndrome 0, both flags low, and the data unchanged.
- R4: A read with exactly one data bit j flipped gives syndrome equal to column j and `chk_single` = 1. `chk_data` holds the original word.
- R5: A flip of data bit 0 alone gives syndrome 0xE3, and the corrector restores bit 0.
- R6: A flip of check bit r alone gives syndrome (1 << r) and `chk_single` = 1, with `chk_data` equal to the read data.
- R7: Any two flipped bits among the 72 stored bits give `chk_double` = 1 and `chk_single` = 0, and `chk_data` equals the read data unmodified.
- R8: A nonzero syndrome that is neither a data column nor a unit vector, including every odd value of weight 7, is reported as `chk_double` = 1 with the data passed through.
- R9: `chk_valid` is high exactly one cycle after `rd_valid`. The two flags are low whenever `chk_valid` is low. After reset, all registered outputs are zero.
- R10: The write encoder is purely combinational and runs alongside the read path. A read in flight does not change `enc_check`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_data | input | 64 | Data word to be written |
| enc_check | output | 8 | Check byte for `wr_data` |
| rd_valid | input | 1 | Read word and check byte are present this cycle |
| rd_data | input | 64 | Data word returned by the memory |
| rd_check | input | 8 | Check byte returned by the memory |
| chk_valid | output | 1 | Registered read result is valid |
| chk_data | output | 64 | Corrected (or passed-through) data |
| chk_single | output | 1 | Single-bit error found and handled |
| chk_double | output | 1 | Uncorrectable error found |
| chk_syndrome | output | 8 | Raw syndrome of the read |

## Verification
Encoding a write and decoding a read can fall in the same cycle, since the two paths share the parity matrix but no state. The bench drives a new random `wr_data` in every cycle that also carries a read strobe. It checks `enc_check` against its own encoder before the clock edge, and the registered read result after it. Both paths are judged against bench functions built only from the column rule in R2.

// File: rtl/secded_pkg.sv
// Package: shared widths and the parity-check column code.
// Assumes an 8-bit check byte, which leaves room for 112 odd-weight columns
// of weight 3 or 5, more than the 64 that the data word needs.
package secded_pkg;

    localparam int DATA_W  = 64;
    localparam int CHK_W   = 8;
    localparam logic [CHK_W-1:0] INV_MASK  = 8'h0C;
    localparam logic [CHK_W-1:0] BIT0_COL  = 8'hE3;

    // Count the set bits in a check-width value.
    function automatic int weight_of(input logic [CHK_W-1:0] v);
        int n;
        n = 0;
        for (int b = 0; b < CHK_W; b++) n += int'(v[b]);
        return n;
    endfunction

    // Column code of data bit idx. Bit 0 takes a fixed code; the rest walk
    // the weight-3/5 values in ascending order and skip that fixed code.
    function automatic logic [CHK_W-1:0] col_code(input int idx);
        int seen;
        logic [CHK_W-1:0] res;
        seen = 0;
        res  = '0;
        if (idx == 0) begin
            res = BIT0_COL;
        end else begin
            for (int v = 1; v < (1 << CHK_W); v++) begin
                if ((weight_of(CHK_W'(v)) == 3 || weight_of(CHK_W'(v)) == 5)
                    && CHK_W'(v) != BIT0_COL) begin
                    seen++;
                    if (seen == idx) res = CHK_W'(v);
                end
            end
        end
        return res;
    endfunction

endpackage

// File: rtl/secded_parity_gen.sv
// Module: raw parity generator.
// Computes the XOR of the column codes of all set data bits, then applies
// the inversion mask. Purely combinational; one instance per path.
module secded_parity_gen
    import secded_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int CW = CHK_W,
    parameter logic [CW-1:0] INV = INV_MASK
) (
    input  logic [DW-1:0] data_in,
    output logic [CW-1:0] check_out
);

    logic [CW-1:0] contrib [DW];

    // One column contribution per data bit, zero when the bit is clear.
    for (genvar i = 0; i < DW; i++) begin : g_col
        localparam logic [CW-1:0] COLV = CW'(col_code(i));
        assign contrib[i] = data_in[i] ? COLV : '0;
    end

    // Fold all contributions and apply the fixed inversion.
    always_comb begin
        logic [CW-1:0] acc;
        acc = INV;
        for (int i = 0; i < DW; i++) acc ^= contrib[i];
        check_out = acc;
    end

endmodule

// File: rtl/secded_syndrome_decode.sv
// Module: syndrome classifier.
// Maps a syndrome to a data flip mask and to single/double flags.
// Assumes columns are odd weight and distinct from the unit vectors, so
// a unit-vector syndrome always means a check-bit error.
module secded_syndrome_decode
    import secded_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int CW = CHK_W
) (
    input  logic [CW-1:0] syndrome,
    output logic [DW-1:0] flip_mask,
    output logic          is_single,
    output logic          is_double
);

    logic [DW-1:0] col_hit;
    logic          unit_hit;
    logic          nonzero;

    // Per-bit column compare; at most one can match.
    for (genvar i = 0; i < DW; i++) begin : g_hit
        localparam logic [CW-1:0] COLV = CW'(col_code(i));
        assign col_hit[i] = (syndrome == COLV);
    end

    // Check-bit error detection: exactly one syndrome bit set.
    always_comb begin
        unit_hit = $onehot(syndrome);
        nonzero  = |syndrome;
    end

    // Final classification and correction mask.
    always_comb begin
        flip_mask = col_hit;
        is_single = nonzero && ((|col_hit) || unit_hit);
        is_double = nonzero && !((|col_hit) || unit_hit);
    end

endmodule

// File: rtl/secded_ecc_unit.sv
// Module: top of the ECC block.
// Write side: combinational check byte for wr_data.
// Read side: recompute, syndrome, classify, correct; result registered one
// cycle after rd_valid. Synchronous active-low reset clears all registers.
module secded_ecc_unit
    import secded_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] wr_data,
    output logic [CHK_W-1:0]  enc_check,
    input  logic              rd_valid,
    input  logic [DATA_W-1:0] rd_data,
    input  logic [CHK_W-1:0]  rd_check,
    output logic              chk_valid,
    output logic [DATA_W-1:0] chk_data,
    output logic              chk_single,
    output logic              chk_double,
    output logic [CHK_W-1:0]  chk_syndrome
);

    logic [CHK_W-1:0]  rd_recalc;
    logic [CHK_W-1:0]  syn_c;
    logic [DATA_W-1:0] flip_c;
    logic              single_c;
    logic              double_c;

    secded_parity_gen #(.DW(DATA_W), .CW(CHK_W)) u_wr_gen (
        .data_in   (wr_data),
        .check_out (enc_check)
    );

    secded_parity_gen #(.DW(DATA_W), .CW(CHK_W)) u_rd_gen (
        .data_in   (rd_data),
        .check_out (rd_recalc)
    );

    // Syndrome: stored byte against recomputed byte; inversion cancels.
    always_comb syn_c = rd_check ^ rd_recalc;

    secded_syndrome_decode #(.DW(DATA_W), .CW(CHK_W)) u_dec (
        .syndrome  (syn_c),
        .flip_mask (flip_c),
        .is_single (single_c),
        .is_double (double_c)
    );

    // Result register: loads on a read strobe, flags gated by the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_valid    <= 1'b0;
            chk_data     <= '0;
            chk_single   <= 1'b0;
            chk_double   <= 1'b0;
            chk_syndrome <= '0;
        end else begin
            chk_valid  <= rd_valid;
            chk_single <= rd_valid & single_c;
            chk_double <= rd_valid & double_c;
            if (rd_valid) begin
                chk_data     <= rd_data ^ flip_c;
                chk_syndrome <= syn_c;
            end
        end
    end

endmodule

// File: rtl/secded_ecc_unit_chk.sv
// Checker: temporal properties of secded_ecc_unit, observed at its ports.
module secded_ecc_unit_chk
    import secded_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] wr_data,
    input logic [CHK_W-1:0]  enc_check,
    input logic              rd_valid,
    input logic [DATA_W-1:0] rd_data,
    input logic [CHK_W-1:0]  rd_check,
    input logic              chk_valid,
    input logic [DATA_W-1:0] chk_data,
    input logic              chk_single,
    input logic              chk_double,
    input logic [CHK_W-1:0]  chk_syndrome
);

    a_r1_zero_word: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data == '0) |-> (enc_check == INV_MASK));

    a_r9_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> chk_valid);

    a_r9_valid_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |=> !chk_valid);

    a_r9_flags_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_valid |-> (!chk_single && !chk_double));

    a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(chk_single && chk_double));

    a_r3_clean_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && chk_syndrome == '0) |-> (!chk_single && !chk_double));

    a_r6_unit_single: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && $onehot(chk_syndrome)) |-> chk_single);

    a_r8_even_double: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && chk_syndrome != '0 && !(^chk_syndrome)) |-> chk_double);

    a_r4_at_most_one_flip: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> ($countones(chk_data ^ $past(rd_data)) <= 1));

    a_r7_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> (chk_double -> (chk_data == $past(rd_data))));

endmodule

bind secded_ecc_unit secded_ecc_unit_chk u_chk (.*);

// File: tb/secded_ecc_unit_test.sv
module secded_ecc_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] wr_data = '0;
    logic [7:0]  enc_check;
    logic        rd_valid = 1'b0;
    logic [63:0] rd_data = '0;
    logic [7:0]  rd_check = '0;
    logic        chk_valid;
    logic [63:0] chk_data;
    logic        chk_single;
    logic        chk_double;
    logic [7:0]  chk_syndrome;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    secded_ecc_unit uut (
        .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .enc_check(enc_check),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_check(rd_check),
        .chk_valid(chk_valid), .chk_data(chk_data), .chk_single(chk_single),
        .chk_double(chk_double), .chk_syndrome(chk_syndrome)
    );

    // Bench column table, built from the rule in R2.
    logic [7:0] cols [64];
    initial begin
        int k;
        cols[0] = 8'hE3;
        k = 1;
        for (int v = 1; v < 256 && k < 64; v++) begin
            if (($countones(8'(v)) == 3 || $countones(8'(v)) == 5) && v != 'hE3) begin
                cols[k] = 8'(v);
                k++;
            end
        end
    end

    function automatic logic [7:0] ref_enc(input logic [63:0] d);
        logic [7:0] a;
        a = 8'h0C;
        for (int i = 0; i < 64; i++) if (d[i]) a ^= cols[i];
        return a;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Apply a read, with a fresh write word in the same cycle (R10), then
    // judge the registered result. orig is the word the corrector should give.
    task automatic do_read(input logic [63:0] d, input logic [7:0] c,
                           input logic [63:0] exp_data, input logic [7:0] exp_syn,
                           input bit exp_s, input bit exp_d, input string req);
        logic [63:0] w;
        w = {$urandom, $urandom};
        @(negedge clk);
        rd_valid = 1'b1; rd_data = d; rd_check = c; wr_data = w;
        #1 check("R10 enc during read", 64'(enc_check), 64'(ref_enc(w)));
        @(negedge clk);
        rd_valid = 1'b0;
        check({req, " valid"},  64'(chk_valid), 64'd1);
        check({req, " data"},   chk_data, exp_data);
        check({req, " syn"},    64'(chk_syndrome), 64'(exp_syn));
        check({req, " single"}, 64'(chk_single), 64'(exp_s));
        check({req, " double"}, 64'(chk_double), 64'(exp_d));
    endtask

    initial begin
        logic [63:0] d;
        logic [7:0]  c;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 reset valid",  64'(chk_valid), 64'd0);
        check("R9 reset data",   chk_data, 64'd0);
        check("R9 reset syn",    64'(chk_syndrome), 64'd0);
        check("R9 reset flags",  64'({chk_single, chk_double}), 64'd0);
        rst_n = 1'b1;

        // R1: zero word encodes to 0x0C
        wr_data = '0;
        #1 check("R1 zero encode", 64'(enc_check), 64'h0C);
        // R2: single-bit words encode to column ^ 0x0C
        for (int j = 0; j < 64; j += 9) begin
            wr_data = 64'd1 << j;
            #1 check("R2 column encode", 64'(enc_check), 64'(cols[j] ^ 8'h0C));
        end

        // R3: clean zero word
        do_read(64'd0, 8'h0C, 64'd0, 8'h00, 0, 0, "R3 clean zero");
        // R5: data bit 0 flipped on zero memory
        do_read(64'd1, 8'h0C, 64'd0, 8'hE3, 1, 0, "R5 bit0");
        // R4: data bit 15 flipped
        do_read(64'h8000, 8'h0C, 64'd0, cols[15], 1, 0, "R4 bit15");
        // R6: each check bit flipped on a fixed word
        d = 64'hDEAD_BEEF_0123_4567;
        for (int r = 0; r < 8; r++)
            do_read(d, ref_enc(d) ^ (8'd1 << r), d, 8'd1 << r, 1, 0, "R6 check bit");
        // R7: bits 0 and 63
        d = 64'h8000_0000_0000_0001;
        do_read(d, 8'h0C, d, cols[0] ^ cols[63], 0, 1, "R7 two data bits");
        // R8: weight-7 syndrome
        d = 64'h0F0F_0F0F_0F0F_0F0F;
        do_read(d, ref_enc(d) ^ 8'h7F, d, 8'h7F, 0, 1, "R8 weight7");

        // R9: valid and flags drop with no strobe
        @(negedge clk);
        check("R9 idle valid", 64'(chk_valid), 64'd0);
        check("R9 idle flags", 64'({chk_single, chk_double}), 64'd0);

        // Random mix: clean, one data flip, one check flip, two flips
        for (int it = 0; it < 300; it++) begin
            int kind;
            int p, q;
            logic [71:0] cw, err;
            d = {$urandom, $urandom};
            c = ref_enc(d);
            cw = {c, d};
            kind = int'($urandom % 4);
            err = '0;
            if (kind == 1) err[$urandom % 64] = 1'b1;
            else if (kind == 2) err[64 + ($urandom % 8)] = 1'b1;
            else if (kind == 3) begin
                p = int'($urandom % 72);
                q = (p + 1 + int'($urandom % 71)) % 72;
                err[p] = 1'b1; err[q] = 1'b1;
            end
            cw ^= err;
            if (kind == 0)
                do_read(cw[63:0], cw[71:64], d, 8'h00, 0, 0, "R3 random clean");
            else if (kind == 1)
                do_read(cw[63:0], cw[71:64], d, cw[71:64] ^ ref_enc(cw[63:0]) ^ 8'h0C ^ 8'h0C, 1, 0, "R4 random data flip");
            else if (kind == 2)
                do_read(cw[63:0], cw[71:64], d, err[71:64], 1, 0, "R6 random check flip");
            else
                do_read(cw[63:0], cw[71:64], cw[63:0], cw[71:64] ^ ref_enc(cw[63:0]), 0, 1, "R7 random double");
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R9 watchdog: actual hung expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule